// File: doc/BRIEF.md
# Address Table Violation Capture

This block sits beside the lookup engine of a switch's address table. Whenever a lookup reports a problem, it keeps a record of the event. A problem can be a frame whose source port is not a member of the matching entry, a lookup that finds no entry, or a learn attempt that finds the table full. The record holds the event's kind flags, the frame's source address (MAC), its database number, its ingress port and the port vector involved. While a record is pending, a problem interrupt is raised.

Software retrieves the record by writing a get-and-clear command to the shared operation register. The busy bit must be set in that write. The block then copies the record into the shared result registers and empties the record. The ingress port comes back in the entry-state field, and the three kind flags come back in the operation register. Only the first event is kept. Later events are dropped until the record is cleared, and a dropped event sets an overflow flag.

Top module: `addr_tbl_viol_cap`

## Requirements
- R1: After reset, `irq_prob`, `op_busy`, every flag and every result field are zero.
- R2: An event is any of `evt_member`, `evt_miss`, `evt_full` high at a clock edge. If nothing is pending, the event is captured and `irq_prob` is high from the next cycle.
- R3: A write with `op_wr=1`, `op_busy_bit=1` and `op_code=3'b110` starts get-and-clear. `op_busy` is high for exactly two cycles after the accepting edge. The results load and `irq_prob` falls at the second edge, and `op_busy` falls at the third.
- R4: The flags report the captured kinds on separate outputs: `flag_member`, `flag_miss` and `flag_full`. Each is set if its strobe was high in the captured event, so several may be set together.
- R5: `ent_state` returns the 4-bit source port of the captured frame. `ent_portvec`, `ent_mac` and `ent_db` return that frame's port vector, address and database number.
- R6: While a record is pending, a further event leaves the record unchanged and sets overflow. `flag_overflow` reports it at the next get-and-clear, and the clear resets it.
- R7: Get-and-clear with no record pending returns all flags and all result fields as zero.
- R8: An operation write with the busy bit clear, or with any other opcode, starts nothing, and `op_busy` and `irq_prob` are unchanged.
- R9: Get-and-clear writes that arrive while `op_busy` is high are ignored and do not lengthen the busy window.
- R10: An event at the same edge where a clear completes becomes the new record: `irq_prob` stays high and the next get-and-clear returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_member | input | 1 | Lookup reports a membership violation |
| evt_miss | input | 1 | Lookup reports a miss violation |
| evt_full | input | 1 | Lookup reports a table-full violation |
| evt_spid | input | SPID_W | Ingress port of the offending frame |
| evt_portvec | input | PORTS | Port vector of the offending lookup |
| evt_mac | input | MAC_W | Address of the offending frame |
| evt_db | input | DB_W | Database number of the offending lookup |
| op_wr | input | 1 | Write strobe of the operation register |
| op_busy_bit | input | 1 | Busy bit value in the write |
| op_code | input | 3 | Opcode value in the write |
| op_busy | output | 1 | Operation in progress |
| flag_member | output | 1 | Returned membership flag |
| flag_miss | output | 1 | Returned miss flag |
| flag_full | output | 1 | Returned full flag |
| flag_overflow | output | 1 | Events were dropped behind the returned one |
| ent_state | output | SPID_W | Entry-state field carrying the source port |
| ent_portvec | output | PORTS | Returned port vector |
| ent_mac | output | MAC_W | Returned address |
| ent_db | output | DB_W | Returned database number |
| irq_prob | output | 1 | Problem interrupt, high while a record is pending |

## Verification
An event driven before edge N is visible on `irq_prob` one cycle later. The bench drives on falling edges and checks the interrupt at the following falling edge. A get-and-clear accepted at edge N shows busy after N, results and the dropped interrupt after N+1, and idle after N+2. The driver task checks busy and the interrupt at each of those three falling edges. The scoreboard monitor compares the result fields with the queued expectation at the falling edge where busy is first seen low, after the results have settled.

// File: rtl/avc_pkg.sv
package avc_pkg;

  localparam logic [2:0] OPC_GET_CLR = 3'b110;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_DONE = 2'd2
  } seq_t;

  // command is accepted only with busy bit set and the get-and-clear opcode
  function automatic logic cmd_hits(input logic wr, input logic busy_bit,
                                    input logic [2:0] code);
    return wr && busy_bit && (code == OPC_GET_CLR);
  endfunction

  // kinds vector order: {full, miss, member}
  function automatic logic [2:0] pack_kinds(input logic member, input logic miss,
                                            input logic full);
    return {full, miss, member};
  endfunction

endpackage

// File: rtl/avc_cmd_seq.sv
module avc_cmd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_hit,
  output logic busy,
  output logic load
);
  import avc_pkg::*;

  seq_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
    end else begin
      unique case (state)
        SEQ_IDLE: if (cmd_hit) state <= SEQ_LOAD;
        SEQ_LOAD: state <= SEQ_DONE;
        SEQ_DONE: state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy = (state != SEQ_IDLE);
  assign load = (state == SEQ_LOAD);

endmodule

// File: rtl/avc_record.sv
module avc_record #(
  parameter int PORTS  = 11,
  parameter int DB_W   = 12,
  parameter int MAC_W  = 48,
  parameter int SPID_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        evt_kinds,
  input  logic [SPID_W-1:0] evt_spid,
  input  logic [PORTS-1:0]  evt_portvec,
  input  logic [MAC_W-1:0]  evt_mac,
  input  logic [DB_W-1:0]   evt_db,
  input  logic              clr,
  output logic              capture_evt,
  output logic              drop_evt,
  output logic              pending,
  output logic              ovf,
  output logic [2:0]        kinds,
  output logic [SPID_W-1:0] spid,
  output logic [PORTS-1:0]  portvec,
  output logic [MAC_W-1:0]  mac,
  output logic [DB_W-1:0]   db
);

  logic any_evt;
  assign any_evt     = |evt_kinds;
  // a clear completing frees the slot in the same cycle
  assign capture_evt = any_evt && (!pending || clr);
  assign drop_evt    = any_evt && pending && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      ovf     <= 1'b0;
      kinds   <= '0;
      spid    <= '0;
      portvec <= '0;
      mac     <= '0;
      db      <= '0;
    end else if (capture_evt) begin
      pending <= 1'b1;
      ovf     <= 1'b0;
      kinds   <= evt_kinds;
      spid    <= evt_spid;
      portvec <= evt_portvec;
      mac     <= evt_mac;
      db      <= evt_db;
    end else if (clr) begin
      pending <= 1'b0;
      ovf     <= 1'b0;
      kinds   <= '0;
      spid    <= '0;
      portvec <= '0;
      mac     <= '0;
      db      <= '0;
    end else if (drop_evt) begin
      ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/addr_tbl_viol_cap.sv
module addr_tbl_viol_cap #(
  parameter int PORTS  = 11,
  parameter int DB_W   = 12,
  parameter int MAC_W  = 48,
  parameter int SPID_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_member,
  input  logic              evt_miss,
  input  logic              evt_full,
  input  logic [SPID_W-1:0] evt_spid,
  input  logic [PORTS-1:0]  evt_portvec,
  input  logic [MAC_W-1:0]  evt_mac,
  input  logic [DB_W-1:0]   evt_db,
  input  logic              op_wr,
  input  logic              op_busy_bit,
  input  logic [2:0]        op_code,
  output logic              op_busy,
  output logic              flag_member,
  output logic              flag_miss,
  output logic              flag_full,
  output logic              flag_overflow,
  output logic [SPID_W-1:0] ent_state,
  output logic [PORTS-1:0]  ent_portvec,
  output logic [MAC_W-1:0]  ent_mac,
  output logic [DB_W-1:0]   ent_db,
  output logic              irq_prob
);
  import avc_pkg::*;

  // named internal events, observed by the bound checker
  logic              cmd_hit;
  logic              cmd_load;
  logic              capture_evt;
  logic              drop_evt;
  logic              rec_pending;
  logic              rec_ovf;
  logic [2:0]        rec_kinds;
  logic [SPID_W-1:0] rec_spid;
  logic [PORTS-1:0]  rec_portvec;
  logic [MAC_W-1:0]  rec_mac;
  logic [DB_W-1:0]   rec_db;

  assign cmd_hit = cmd_hits(op_wr, op_busy_bit, op_code) && !op_busy;

  avc_cmd_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_hit (cmd_hit),
    .busy    (op_busy),
    .load    (cmd_load)
  );

  avc_record #(
    .PORTS  (PORTS),
    .DB_W   (DB_W),
    .MAC_W  (MAC_W),
    .SPID_W (SPID_W)
  ) u_rec (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_kinds   (pack_kinds(evt_member, evt_miss, evt_full)),
    .evt_spid    (evt_spid),
    .evt_portvec (evt_portvec),
    .evt_mac     (evt_mac),
    .evt_db      (evt_db),
    .clr         (cmd_load),
    .capture_evt (capture_evt),
    .drop_evt    (drop_evt),
    .pending     (rec_pending),
    .ovf         (rec_ovf),
    .kinds       (rec_kinds),
    .spid        (rec_spid),
    .portvec     (rec_portvec),
    .mac         (rec_mac),
    .db          (rec_db)
  );

  // shared result registers, loaded when the clear completes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_member   <= 1'b0;
      flag_miss     <= 1'b0;
      flag_full     <= 1'b0;
      flag_overflow <= 1'b0;
      ent_state     <= '0;
      ent_portvec   <= '0;
      ent_mac       <= '0;
      ent_db        <= '0;
    end else if (cmd_load) begin
      flag_member   <= rec_kinds[0];
      flag_miss     <= rec_kinds[1];
      flag_full     <= rec_kinds[2];
      flag_overflow <= rec_ovf;
      ent_state     <= rec_spid;
      ent_portvec   <= rec_portvec;
      ent_mac       <= rec_mac;
      ent_db        <= rec_db;
    end
  end

  assign irq_prob = rec_pending;

endmodule

// File: rtl/addr_tbl_viol_cap_chk.sv
module addr_tbl_viol_cap_chk #(
  parameter int MAC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_hit,
  input logic             cmd_load,
  input logic             capture_evt,
  input logic             drop_evt,
  input logic             rec_pending,
  input logic             rec_ovf,
  input logic [MAC_W-1:0] rec_mac,
  input logic             op_busy,
  input logic             irq_prob,
  input logic             flag_member,
  input logic             flag_miss,
  input logic             flag_full
);

  p_irq_on_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> irq_prob);

  p_busy_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |=> (op_busy ##1 !op_busy));

  p_irq_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && !capture_evt) |=> !irq_prob);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (rec_ovf && rec_pending && $stable(rec_mac)));

  p_empty_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && !rec_pending) |=> !(flag_member || flag_miss || flag_full));

  p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_busy && !cmd_hit) |=> !op_busy);

  p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && !cmd_load) |=> !cmd_load);

endmodule

bind addr_tbl_viol_cap addr_tbl_viol_cap_chk #(.MAC_W(MAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_hit     (cmd_hit),
  .cmd_load    (cmd_load),
  .capture_evt (capture_evt),
  .drop_evt    (drop_evt),
  .rec_pending (rec_pending),
  .rec_ovf     (rec_ovf),
  .rec_mac     (rec_mac),
  .op_busy     (op_busy),
  .irq_prob    (irq_prob),
  .flag_member (flag_member),
  .flag_miss   (flag_miss),
  .flag_full   (flag_full)
);

// File: tb/addr_tbl_viol_cap_test.sv
module addr_tbl_viol_cap_test;
  localparam int PORTS  = 11;
  localparam int DB_W   = 12;
  localparam int MAC_W  = 48;
  localparam int SPID_W = 4;

  typedef struct packed {
    logic              ovf;
    logic              full;
    logic              miss;
    logic              member;
    logic [SPID_W-1:0] spid;
    logic [PORTS-1:0]  pv;
    logic [DB_W-1:0]   db;
    logic [MAC_W-1:0]  mac;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_member = 0, evt_miss = 0, evt_full = 0;
  logic [SPID_W-1:0] evt_spid = '0;
  logic [PORTS-1:0]  evt_portvec = '0;
  logic [MAC_W-1:0]  evt_mac = '0;
  logic [DB_W-1:0]   evt_db = '0;
  logic op_wr = 0, op_busy_bit = 0;
  logic [2:0] op_code = '0;
  logic op_busy, flag_member, flag_miss, flag_full, flag_overflow, irq_prob;
  logic [SPID_W-1:0] ent_state;
  logic [PORTS-1:0]  ent_portvec;
  logic [MAC_W-1:0]  ent_mac;
  logic [DB_W-1:0]   ent_db;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  item_t exp_q[$];
  item_t mdl;
  bit mdl_pend = 0;

  always #5 clk = ~clk;

  addr_tbl_viol_cap #(.PORTS(PORTS), .DB_W(DB_W), .MAC_W(MAC_W), .SPID_W(SPID_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .evt_member(evt_member), .evt_miss(evt_miss), .evt_full(evt_full),
    .evt_spid(evt_spid), .evt_portvec(evt_portvec), .evt_mac(evt_mac), .evt_db(evt_db),
    .op_wr(op_wr), .op_busy_bit(op_busy_bit), .op_code(op_code),
    .op_busy(op_busy), .flag_member(flag_member), .flag_miss(flag_miss),
    .flag_full(flag_full), .flag_overflow(flag_overflow), .ent_state(ent_state),
    .ent_portvec(ent_portvec), .ent_mac(ent_mac), .ent_db(ent_db), .irq_prob(irq_prob)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic item_t make_item(input logic mem, input logic mis, input logic ful,
                                      input logic [SPID_W-1:0] sp, input logic [PORTS-1:0] pv,
                                      input logic [DB_W-1:0] db, input logic [MAC_W-1:0] mac);
    item_t it;
    it.ovf = 1'b0; it.member = mem; it.miss = mis; it.full = ful;
    it.spid = sp; it.pv = pv; it.db = db; it.mac = mac;
    return it;
  endfunction

  // drive event fields for one edge; bench model of first-event hold
  task automatic put_event(input item_t it);
    evt_member = it.member; evt_miss = it.miss; evt_full = it.full;
    evt_spid = it.spid; evt_portvec = it.pv; evt_db = it.db; evt_mac = it.mac;
    if (!mdl_pend) begin mdl = it; mdl.ovf = 1'b0; mdl_pend = 1; end
    else mdl.ovf = 1'b1;
  endtask

  task automatic clear_event();
    evt_member = 0; evt_miss = 0; evt_full = 0;
  endtask

  task automatic fire(input item_t it);
    @(negedge clk);
    put_event(it);
    @(negedge clk);
    clear_event();
    check(irq_prob === 1'b1, "R2 irq after event", 128'(irq_prob), 128'(1));
  endtask

  // get-and-clear driver; hammer keeps writing during busy (R9);
  // inject supplies an event timed for the completion edge (R10)
  task automatic run_clear(input bit hammer, input bit inject, input item_t inj);
    item_t e;
    @(negedge clk);
    op_wr = 1; op_busy_bit = 1; op_code = 3'b110;
    e = mdl_pend ? mdl : '0;
    exp_q.push_back(e);
    mdl_pend = 0; mdl = '0;
    @(negedge clk);
    check(op_busy === 1'b1, "R3 busy after accept", 128'(op_busy), 128'(1));
    if (!hammer) op_wr = 0;
    if (inject) put_event(inj);
    @(negedge clk);
    clear_event();
    check(op_busy === 1'b1, hammer ? "R9 busy second cycle" : "R3 busy second cycle",
          128'(op_busy), 128'(1));
    check(irq_prob === inject, inject ? "R10 irq kept by new event" : "R3 irq dropped",
          128'(irq_prob), 128'(inject));
    @(negedge clk);
    op_wr = 0;
    check(op_busy === 1'b0, hammer ? "R9 busy not lengthened" : "R3 busy falls",
          128'(op_busy), 128'(0));
  endtask

  // scoreboard monitor: compare results once busy is seen low
  logic prev_busy = 1'b0;
  always @(negedge clk) begin
    if (prev_busy && !op_busy) begin
      item_t got, e;
      got.ovf = flag_overflow; got.full = flag_full; got.miss = flag_miss;
      got.member = flag_member; got.spid = ent_state; got.pv = ent_portvec;
      got.db = ent_db; got.mac = ent_mac;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected completion", 128'(got), 128'(0));
      end else begin
        e = exp_q.pop_front();
        check(got === e, "R4 R5 R6 R7 readback", 128'(got), 128'(e));
      end
    end
    prev_busy = op_busy;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    item_t a, b, c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(irq_prob === 0 && op_busy === 0, "R1 irq/busy", 128'({irq_prob, op_busy}), 128'(0));
    check({flag_member, flag_miss, flag_full, flag_overflow, ent_state, ent_portvec, ent_db, ent_mac} === '0,
          "R1 results zero", 128'({ent_state, ent_db}), 128'(0));

    // R7 clear with nothing pending
    run_clear(0, 0, '0);

    // R2 R4 R5 single membership event
    a = make_item(1, 0, 0, 4'd5, 11'h2A5, 12'h123, 48'h0011_2233_4455);
    fire(a);
    run_clear(0, 0, '0);

    // R4 R6: two kinds together, then a dropped event
    a = make_item(0, 1, 1, 4'd10, 11'h7FF, 12'hFFF, 48'hFFFF_FFFF_FFFE);
    fire(a);
    b = make_item(1, 0, 0, 4'd3, 11'h001, 12'h001, 48'h0102_0304_0506);
    fire(b);
    check(irq_prob === 1, "R6 irq still pending", 128'(irq_prob), 128'(1));
    run_clear(0, 0, '0);

    // R6 overflow reset by the clear: a fresh event reports overflow zero
    c = make_item(0, 0, 1, 4'd0, 11'h400, 12'h800, 48'h8000_0000_0000);
    fire(c);

    // R8 wrong opcode and missing busy bit are ignored
    @(negedge clk);
    op_wr = 1; op_busy_bit = 1; op_code = 3'b010;
    @(negedge clk);
    check(op_busy === 0, "R8 other opcode ignored", 128'(op_busy), 128'(0));
    op_busy_bit = 0; op_code = 3'b110;
    @(negedge clk);
    op_wr = 0;
    check(op_busy === 0, "R8 busy bit clear ignored", 128'(op_busy), 128'(0));
    check(irq_prob === 1, "R8 irq unchanged", 128'(irq_prob), 128'(1));
    run_clear(0, 0, '0);

    // R9 writes during busy ignored
    a = make_item(0, 1, 0, 4'd7, 11'h0F0, 12'h0AA, 48'hDEAD_BEEF_0001);
    fire(a);
    run_clear(1, 0, '0);
    @(negedge clk);
    check(op_busy === 0, "R9 no restart", 128'(op_busy), 128'(0));

    // R10 event at the completion edge becomes the new record
    a = make_item(1, 1, 0, 4'd1, 11'h155, 12'h321, 48'hAAAA_5555_AAAA);
    fire(a);
    b = make_item(0, 0, 1, 4'd12, 11'h2AA, 12'h654, 48'h5555_AAAA_5555);
    run_clear(0, 1, b);
    check(irq_prob === 1, "R10 irq still high", 128'(irq_prob), 128'(1));
    run_clear(0, 0, '0);
    check(irq_prob === 0, "R10 irq low after second clear", 128'(irq_prob), 128'(0));

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 all results seen", 128'(exp_q.size()), 128'(0));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule